// File: doc/BRIEF.md
# Multi-cycle 16-bit FSMD processor core

This block is a compact 16-bit processor made of a finite-state controller and a separate datapath. The datapath contains a program counter, an instruction register, a register file of sixteen 16-bit entries with two read ports and one write port, and one ALU that raises a zero flag. The controller talks to the datapath through a small bundle of strobes. Those strobes load or step the program counter, capture the instruction, write the register file, select the write source and the memory address source, pick the ALU operation, and arm the conditional branch.

The core uses a single memory for both program and data. The memory has 16-bit words and a 16-bit address, separate read and write data buses, and one enable for reads and one for writes. Reads are synchronous: data appears on the cycle after the address is presented. Each instruction goes through Fetch (two cycles), Decode and then one execute state. The direct load takes two execute cycles. Every other instruction takes one.

Top module: `fsmd_core`

## Requirements
- R1: A synchronous active-high reset drives both memory enables low for the cycle after each reset edge. The first read after reset is from address 0.
- R2: A fetch reads M[PC] and captures it into the instruction register on the following cycle. The PC then advances by one, so consecutive instructions are fetched from consecutive addresses.
- R3: The instruction word is split as follows. Bits 15:12 hold the opcode, bits 11:8 hold the destination/base register rn, and bits 7:4 hold the second register rm. Bits 7:0 are shared by the direct address, the immediate and the branch offset.
- R4: Opcode 0x0 issues a read of the word at the zero-extended IR[7:0] and writes the returned data into rn. Opcode 0x3 writes the zero-extended IR[7:0] into rn.
- R5: Opcode 0x1 asserts the write enable for one cycle. The address is the zero-extended IR[7:0] and the data is rn.
- R6: Opcode 0x2 asserts the write enable for one cycle. The address is the contents of rn and the data is the contents of rm.
- R7: Opcode 0x4 sets rn to rn + rm and opcode 0x5 sets rn to rn − rm. Both wrap modulo 2^16.
- R8: Opcode 0x6 tests rn. If rn is zero, the PC becomes the incremented PC plus the sign-extended IR[7:0]. Otherwise execution continues with the next word.
- R9: Opcodes 0x7 to 0xF change no register, perform no memory write, and return to fetch.
- R10: The read enable and the write enable are never high in the same cycle. Every write is followed immediately by a fetch read at the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 16 | Memory word address |
| memRdEn | output | 1 | Read request; data is returned on the next cycle |
| memWrEn | output | 1 | Write strobe |
| memWrData | output | 16 | Data to write |
| memRdData | input | 16 | Data read from memory, one cycle after memRdEn |

## Verification
The hardest behaviour to reach from the pins is the taken branch with a negative offset that closes a loop. It only occurs after a subtraction has driven a counter to exactly zero, with several add and subtract passes before that. The stimulus runs a complete loop that sums ten down to one. That loop exercises both the not-taken and the taken branch, the negative offset and the forward exit. The run then stores the result through a direct store and through a register-indirect store, and follows them with an undefined opcode. Wraparound corners of the ALU, such as 0xFFFF + 1 and 0 − 1, are reached by loading 16-bit operands from memory, because the immediate field holds only eight bits.

// File: rtl/fsmd_pkg.sv
package fsmd_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 16;
  localparam int REG_CNT = 16;
  localparam int OPC_W   = 4;
  localparam int FIELD_W = 8;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h0;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STIND = 4'h2;
  localparam logic [OPC_W-1:0] OPC_MOVI  = 4'h3;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h4;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'h5;
  localparam logic [OPC_W-1:0] OPC_JZ    = 4'h6;

  typedef enum logic [1:0] {WSRC_ALU = 2'b00, WSRC_MEM = 2'b01, WSRC_IMM = 2'b10} wsrc_e;
  typedef enum logic [1:0] {ASRC_PC = 2'b00, ASRC_DIR = 2'b01, ASRC_REG = 2'b10} asrc_e;
  typedef enum logic [1:0] {ALU_ADD = 2'b00, ALU_SUB = 2'b01, ALU_PASS = 2'b10} aluop_e;

  typedef struct packed {
    logic   pcClr;
    logic   pcInc;
    logic   jzCheck;
    logic   irLd;
    logic   rfWe;
    wsrc_e  rfSrc;
    asrc_e  addrSrc;
    logic   memRe;
    logic   memWe;
    aluop_e aluOp;
  } strobe_t;

  typedef enum logic [3:0] {
    ST_RESET, ST_FETCH, ST_FWAIT, ST_DECODE, ST_LOAD, ST_LWAIT,
    ST_STORE, ST_STIND, ST_MOVI, ST_ADD, ST_SUB, ST_JZ
  } state_e;
endpackage

// File: rtl/fsmd_ctrl.sv
module fsmd_ctrl
  import fsmd_pkg::*;
#(
  parameter int OW = OPC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] opcode,
  output strobe_t       ctl
);
  state_e state, nxtState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= nxtState;
  end

  always_comb begin
    ctl      = '0;
    nxtState = ST_FETCH;
    unique case (state)
      ST_RESET: ctl.pcClr = 1'b1;
      ST_FETCH: begin
        ctl.memRe   = 1'b1;
        ctl.addrSrc = ASRC_PC;
        nxtState    = ST_FWAIT;
      end
      ST_FWAIT: begin
        ctl.irLd  = 1'b1;
        ctl.pcInc = 1'b1;
        nxtState  = ST_DECODE;
      end
      ST_DECODE: begin
        case (opcode)
          OPC_LOAD:  nxtState = ST_LOAD;
          OPC_STORE: nxtState = ST_STORE;
          OPC_STIND: nxtState = ST_STIND;
          OPC_MOVI:  nxtState = ST_MOVI;
          OPC_ADD:   nxtState = ST_ADD;
          OPC_SUB:   nxtState = ST_SUB;
          OPC_JZ:    nxtState = ST_JZ;
          default:   nxtState = ST_FETCH;
        endcase
      end
      ST_LOAD: begin
        ctl.memRe   = 1'b1;
        ctl.addrSrc = ASRC_DIR;
        nxtState    = ST_LWAIT;
      end
      ST_LWAIT: begin
        ctl.rfWe  = 1'b1;
        ctl.rfSrc = WSRC_MEM;
      end
      ST_STORE: begin
        ctl.memWe   = 1'b1;
        ctl.addrSrc = ASRC_DIR;
      end
      ST_STIND: begin
        ctl.memWe   = 1'b1;
        ctl.addrSrc = ASRC_REG;
      end
      ST_MOVI: begin
        ctl.rfWe  = 1'b1;
        ctl.rfSrc = WSRC_IMM;
      end
      ST_ADD: begin
        ctl.rfWe  = 1'b1;
        ctl.rfSrc = WSRC_ALU;
        ctl.aluOp = ALU_ADD;
      end
      ST_SUB: begin
        ctl.rfWe  = 1'b1;
        ctl.rfSrc = WSRC_ALU;
        ctl.aluOp = ALU_SUB;
      end
      ST_JZ: begin
        ctl.aluOp   = ALU_PASS;
        ctl.jzCheck = 1'b1;
      end
      default: nxtState = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/fsmd_datapath.sv
module fsmd_datapath
  import fsmd_pkg::*;
#(
  parameter int DW   = WORD_W,
  parameter int AW   = ADDR_W,
  parameter int NREG = REG_CNT,
  parameter int OW   = OPC_W,
  parameter int FW   = FIELD_W
) (
  input  logic          clk,
  input  strobe_t       ctl,
  input  logic [DW-1:0] memRdData,
  output logic [OW-1:0] opcode,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWrData,
  output logic [AW-1:0] pcOut
);
  localparam int RAW    = $clog2(NREG);
  localparam int RN_LSB = DW - OW - RAW;
  localparam int RM_LSB = RN_LSB - RAW;

  logic [AW-1:0]  pc;
  logic [DW-1:0]  ir;
  logic [DW-1:0]  regs [NREG];
  logic [RAW-1:0] rnIdx, rmIdx;
  logic [FW-1:0]  field;
  logic [DW-1:0]  rd1, rd2, aluRes, rfWrData;
  logic [AW-1:0]  branchTgt;
  logic           aluZero, takeBranch;

  assign opcode = ir[DW-1 -: OW];
  assign rnIdx  = ir[RN_LSB +: RAW];
  assign rmIdx  = ir[RM_LSB +: RAW];
  assign field  = ir[FW-1:0];
  assign rd1    = regs[rnIdx];
  assign rd2    = regs[rmIdx];

  always_comb begin
    case (ctl.aluOp)
      ALU_ADD: aluRes = rd1 + rd2;
      ALU_SUB: aluRes = rd1 - rd2;
      default: aluRes = rd1;
    endcase
  end
  assign aluZero    = (aluRes == '0);
  assign takeBranch = ctl.jzCheck & aluZero;
  assign branchTgt  = pc + {{(AW-FW){field[FW-1]}}, field};

  always_comb begin
    case (ctl.rfSrc)
      WSRC_MEM: rfWrData = memRdData;
      WSRC_IMM: rfWrData = {{(DW-FW){1'b0}}, field};
      default:  rfWrData = aluRes;
    endcase
  end

  always_comb begin
    case (ctl.addrSrc)
      ASRC_DIR: memAddr = {{(AW-FW){1'b0}}, field};
      ASRC_REG: memAddr = rd1[AW-1:0];
      default:  memAddr = pc;
    endcase
  end
  assign memWrData = (ctl.addrSrc == ASRC_REG) ? rd2 : rd1;
  assign pcOut     = pc;

  always_ff @(posedge clk) begin
    if (ctl.pcClr)      pc <= '0;
    else if (takeBranch) pc <= branchTgt;
    else if (ctl.pcInc)  pc <= pc + 1'b1;
    if (ctl.irLd) ir <= memRdData;
    if (ctl.rfWe) regs[rnIdx] <= rfWrData;
  end
endmodule

// File: rtl/fsmd_core.sv
module fsmd_core
  import fsmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrData,
  input  logic [WORD_W-1:0] memRdData
);
  strobe_t            ctl;
  logic [OPC_W-1:0]   opcode;
  logic [ADDR_W-1:0]  pcNow;

  fsmd_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .ctl    (ctl)
  );

  fsmd_datapath dp_i (
    .clk       (clk),
    .ctl       (ctl),
    .memRdData (memRdData),
    .opcode    (opcode),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .pcOut     (pcNow)
  );

  assign memRdEn = ctl.memRe;
  assign memWrEn = ctl.memWe;
endmodule

// File: rtl/fsmd_core_chk.sv
module fsmd_core_chk
  import fsmd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input strobe_t           ctl,
  input logic [ADDR_W-1:0] pcNow,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdEn,
  input logic              memWrEn
);
  assert_mem_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(memRdEn && memWrEn));

  assert_write_then_fetch_R10: assert property (@(posedge clk) disable iff (rst)
    memWrEn |=> (memRdEn && memAddr == pcNow));

  assert_first_fetch_R1: assert property (@(posedge clk) disable iff (rst)
    ctl.pcClr |=> (pcNow == '0 && memRdEn && memAddr == '0));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.pcInc |=> (pcNow == $past(pcNow) + 1'b1));

  assert_pc_src_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.pcClr, ctl.pcInc, ctl.jzCheck}));

  assert_branch_no_mem_R8: assert property (@(posedge clk) disable iff (rst)
    ctl.jzCheck |-> (!memRdEn && !memWrEn));
endmodule

bind fsmd_core fsmd_core_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .ctl     (ctl),
  .pcNow   (pcNow),
  .memAddr (memAddr),
  .memRdEn (memRdEn),
  .memWrEn (memWrEn)
);

// File: tb/fsmd_core_tb.sv
module fsmd_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] memAddr, memWrData, memRdData;
  logic        memRdEn, memWrEn;

  int total = 0;
  int bad   = 0;

  logic [15:0] mem [256];
  logic [15:0] readLog [8];
  int          logCnt;
  int          wrCount;
  int          bothCnt;

  always #10 clk = ~clk;

  fsmd_core dut_i (
    .clk       (clk),
    .rst       (rst),
    .memAddr   (memAddr),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .memRdData (memRdData)
  );

  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr[7:0]];
    if (rst) begin
      logCnt  <= 0;
      wrCount <= 0;
      bothCnt <= 0;
    end else begin
      if (memWrEn) begin
        mem[memAddr[7:0]] <= memWrData;
        wrCount <= wrCount + 1;
      end
      if (memRdEn && memWrEn) bothCnt <= bothCnt + 1;
      if (memRdEn && logCnt < 8) begin
        readLog[logCnt] <= memAddr;
        logCnt <= logCnt + 1;
      end
    end
  end

  // operand a, operand b, expected a+b, expected a-b
  localparam logic [63:0] VECS [4] = '{
    {16'h0003, 16'h0004, 16'h0007, 16'hFFFF},
    {16'hFFFF, 16'h0001, 16'h0000, 16'hFFFE},
    {16'h8000, 16'h8000, 16'h0000, 16'h0000},
    {16'h1234, 16'h0234, 16'h1468, 16'h1000}
  };

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] rn,
                                      input logic [7:0] fld);
    return {op, rn, fld};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic runProgram(input int cycles);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset keeps the memory bus quiet
    repeat (2) @(negedge clk);
    check("R1 rdEn in reset", {15'd0, memRdEn}, 16'h0000);
    check("R1 wrEn in reset", {15'd0, memWrEn}, 16'h0000);

    // table of ALU vectors, operands loaded from memory (R4, R7)
    for (int v = 0; v < 4; v++) begin
      clearMem();
      mem[0] = enc(4'h3, 4'd4, 8'h00);   // R4 = 0
      mem[1] = enc(4'h0, 4'd1, 8'h80);   // R1 = M[80]
      mem[2] = enc(4'h0, 4'd2, 8'h81);   // R2 = M[81]
      mem[3] = enc(4'h0, 4'd3, 8'h80);   // R3 = M[80]
      mem[4] = enc(4'h4, 4'd1, 8'h20);   // R1 += R2
      mem[5] = enc(4'h5, 4'd3, 8'h20);   // R3 -= R2
      mem[6] = enc(4'h1, 4'd1, 8'h90);   // M[90] = R1
      mem[7] = enc(4'h1, 4'd3, 8'h91);   // M[91] = R3
      mem[8] = enc(4'h6, 4'd4, 8'hFF);   // halt loop
      mem[8'h80] = VECS[v][63:48];
      mem[8'h81] = VECS[v][47:32];
      runProgram(120);
      check("R7 add", mem[8'h90], VECS[v][31:16]);
      check("R7 sub", mem[8'h91], VECS[v][15:0]);
      if (v == 0) begin
        check("R1 first read address", readLog[0], 16'h0000);
        check("R2 second fetch", readLog[1], 16'h0001);
        check("R4 load address", readLog[2], 16'h0080);
        check("R2 third fetch", readLog[3], 16'h0002);
        check("R4 second load address", readLog[4], 16'h0081);
        check("R5 write count", wrCount[15:0], 16'd2);
      end
    end

    // loop summing 10..1, stores, indirect store, undefined opcode (R3, R5, R6, R8, R9)
    clearMem();
    mem[0]  = enc(4'h3, 4'd0, 8'd0);
    mem[1]  = enc(4'h3, 4'd1, 8'd10);
    mem[2]  = enc(4'h3, 4'd2, 8'd1);
    mem[3]  = enc(4'h3, 4'd3, 8'd0);
    mem[4]  = enc(4'h6, 4'd1, 8'h03);    // exit to 8 when R1 == 0
    mem[5]  = enc(4'h4, 4'd0, 8'h10);    // R0 += R1
    mem[6]  = enc(4'h5, 4'd1, 8'h20);    // R1 -= R2
    mem[7]  = enc(4'h6, 4'd3, 8'hFC);    // back to 4
    mem[8]  = enc(4'h1, 4'd0, 8'h95);    // M[95] = R0
    mem[9]  = enc(4'h3, 4'd5, 8'hA0);    // R5 = A0
    mem[10] = enc(4'h2, 4'd5, 8'h00);    // M[R5] = R0
    mem[11] = 16'hF123;                  // undefined
    mem[12] = 16'h7000;                  // undefined
    mem[13] = enc(4'h1, 4'd0, 8'h96);    // M[96] = R0
    mem[14] = enc(4'h6, 4'd3, 8'hFF);    // halt loop
    runProgram(400);
    check("R8 loop sum", mem[8'h95], 16'd55);
    check("R6 R3 indirect store", mem[8'hA0], 16'd55);
    check("R9 undefined leaves R0", mem[8'h96], 16'd55);
    check("R9 write count", wrCount[15:0], 16'd3);
    check("R10 no overlap", bothCnt[15:0], 16'd0);
    check("R1 restart fetch", readLog[0], 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule